// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic read and write one external asynchronous static RAM with a 21-bit address and an 8-bit data bus. A requester offers single-beat commands on a valid/ready port. Each command carries an address, a write flag and a write byte. The controller turns each command into a correctly ordered set of memory strobes. These are two chip selects of opposite polarity, an active-low output enable and an active-low write enable. A read returns its byte on a response port together with a one-clock valid strobe.

Every timing window is a parameter given in nanoseconds. Each one is rounded up to whole clock cycles from the clock period, so a slower speed grade is chosen by overriding the nanosecond values. Every write ends on the rising edge of write enable. Output enable stays high for the whole write. After a read, the controller waits for the memory to release the bus before it drives data. After reset it waits a parameterised power-up interval before it accepts any command. All memory-side outputs come straight from flip-flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever the controller is ready, the memory is deselected: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. `cmd_ready` is 0 while reset is asserted.
- R2: `cmd_ready` first rises after exactly `POWERUP_CYCLES` rising clock edges with reset released. A `cmd_valid` offered before then moves no memory strobe.
- R3: Every access drives `mem_cs_n`=0 and `mem_cs`=1 together, and both return to the deselected levels before the controller is ready again.
- R4: A write holds `mem_we_n` low for ceil(max(write pulse, data setup, address-to-end)/period) cycles, 4 at the defaults. The write byte is driven on `mem_dq_out` with `mem_dq_oe`=1 and kept stable up to the rising edge of `mem_we_n` and for one cycle after it. `mem_oe_n` stays 1 throughout.
- R5: `mem_addr` is registered at acceptance and stays unchanged for as long as the chip selects are active.
- R6: A read holds `mem_oe_n` low from acceptance and captures `mem_dq_in` on the edge ceil(max(address access, output-enable access)/period) cycles after acceptance, 5 at the defaults. `rsp_valid` is high for exactly one cycle right after that edge, with the byte on `rsp_rdata`.
- R7: `cmd_ready` is 0 while an access is in progress. Two acceptances are at least ceil(cycle time/period) clock cycles apart, 5 at the defaults.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It is also never 1 within ceil(output-disable-to-high-Z/period) cycles after `mem_oe_n` rises, 2 at the defaults.
- R9: A read returns the byte most recently written to the same address, for all-zero, all-one and alternating bit patterns and for the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The controller takes the offered command on this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 21 | Byte address |
| cmd_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 21 | Address pins of the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven towards the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
The bench uses a memory model. The model returns the inverted stored byte until the access time has elapsed, so a capture one cycle too early gives a wrong byte rather than a lucky match. The command sequence mixes writes of 0x00, 0xFF, 0x5A, 0xA5 and other bytes at the lowest, highest and alternating-bit addresses. It covers overwrites, read after read, and write straight after read. Write straight after read separates a correct bus turnaround from early driving, which the model flags as contention. Read-back after an overwrite tells a real commit on the rising write-enable edge apart from a stale one. Directed steps then cover the reset levels and the exact power-up edge with a command held pending.

// File: rtl/sram_ctrl_pkg.sv
// Shared helpers for the asynchronous SRAM controller: converts nanosecond
// windows to whole clock cycles and names the access kinds.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    // Round a nanosecond window up to whole clock periods.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_wait.sv
// Power-up gate: counts CYCLES rising edges after reset release, then holds
// done high until the next reset. Assumes CYCLES fits in 32 bits.
module sram_pwrup_wait #(
    parameter int unsigned CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    import sram_ctrl_pkg::*;

    localparam int unsigned PW = max2(CYCLES, 1);
    localparam int unsigned CW = $clog2(PW + 1);
    localparam logic [CW-1:0] LAST = CW'(PW - 1);

    logic [CW-1:0] cnt;

    // Count edges since reset until the interval has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_access_seq.sv
// Strobe sequencer: on start it runs one read or write access and places
// every memory strobe and the data-driver enable on a flip-flop. Offsets are
// counted from the acceptance edge. Assumes WLEN >= WP_C + 2 and
// RLEN >= CAP_C + 1, which the top guarantees.
module sram_access_seq #(
    parameter int unsigned WP_C  = 4,
    parameter int unsigned CAP_C = 5,
    parameter int unsigned WLEN  = 6,
    parameter int unsigned RLEN  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_wr,
    output logic busy,
    output logic cap,
    output logic cs_n,
    output logic cs,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe
);
    import sram_ctrl_pkg::*;

    localparam int unsigned TW = $clog2(max2(WLEN, RLEN) + 1);
    localparam logic [TW-1:0] K_WE_END  = TW'(WP_C - 1);
    localparam logic [TW-1:0] K_WR_REL  = TW'(WP_C);
    localparam logic [TW-1:0] K_WR_DONE = TW'(WLEN - 2);
    localparam logic [TW-1:0] K_CAP     = TW'(CAP_C - 1);
    localparam logic [TW-1:0] K_RD_DONE = TW'(RLEN - 2);

    op_e           op;
    logic [TW-1:0] t;

    assign busy = (op != OP_IDLE);
    assign cap  = (op == OP_READ) && (t == K_CAP);

    // Launch an access from idle, then step its strobes by offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op    <= OP_IDLE;
            t     <= '0;
            cs_n  <= 1'b1;
            cs    <= 1'b0;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else if (op == OP_IDLE) begin
            if (start) begin
                op    <= start_wr ? OP_WRITE : OP_READ;
                t     <= '0;
                cs_n  <= 1'b0;
                cs    <= 1'b1;
                we_n  <= !start_wr;
                oe_n  <= start_wr;
                dq_oe <= start_wr;
            end
        end else begin
            t <= t + 1'b1;
            if (op == OP_WRITE) begin
                if (t == K_WE_END) begin
                    we_n <= 1'b1;
                end
                if (t == K_WR_REL) begin
                    dq_oe <= 1'b0;
                    cs_n  <= 1'b1;
                    cs    <= 1'b0;
                end
                if (t == K_WR_DONE) begin
                    op <= OP_IDLE;
                end
            end else begin
                if (t == K_CAP) begin
                    oe_n <= 1'b1;
                    cs_n <= 1'b1;
                    cs   <= 1'b0;
                end
                if (t == K_RD_DONE) begin
                    op <= OP_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/sram_data_path.sv
// Data path: registers the address and write byte at acceptance and captures
// the read byte on the sequencer's capture pulse. The valid strobe follows
// that capture edge for one cycle.
module sram_data_path #(
    parameter int unsigned AW = 21,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          cap,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    // Hold the command fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (load) begin
            mem_addr   <= cmd_addr;
            mem_dq_out <= cmd_wdata;
        end
    end

    // Capture read data and raise the one-cycle response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap;
            if (cap) begin
                rsp_rdata <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous SRAM controller. Converts nanosecond timing
// parameters to cycle counts, gates commands behind the power-up wait and
// joins the sequencer and the data path. Assumes the memory is the only other
// bus driver and that the data input is settled when captured.
module sram_async_ctrl #(
    parameter int unsigned AW             = 21,
    parameter int unsigned DW             = 8,
    parameter int unsigned CLK_NS         = 10,
    parameter int unsigned T_RC_NS        = 45,
    parameter int unsigned T_PWE_NS       = 35,
    parameter int unsigned T_SD_NS        = 20,
    parameter int unsigned T_AW_NS        = 35,
    parameter int unsigned T_AA_NS        = 45,
    parameter int unsigned T_DOE_NS       = 20,
    parameter int unsigned T_HZ_NS        = 15,
    parameter int unsigned POWERUP_CYCLES = 20000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    import sram_ctrl_pkg::*;

    localparam int unsigned RC_C  = max2(ns_to_cyc(T_RC_NS, CLK_NS), 1);
    localparam int unsigned WP_C  = max2(max2(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                         max2(ns_to_cyc(T_AW_NS, CLK_NS), 1));
    localparam int unsigned CAP_C = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)), 1);
    localparam int unsigned HZ_C  = max2(ns_to_cyc(T_HZ_NS, CLK_NS), 1);
    localparam int unsigned WLEN  = max2(RC_C, WP_C + 2);
    localparam int unsigned RLEN  = max2(RC_C, CAP_C + HZ_C);

    logic pwr_done;
    logic busy;
    logic cap;
    logic accept;

    assign cmd_ready = pwr_done && !busy;
    assign accept    = cmd_valid && cmd_ready;

    sram_pwrup_wait #(.CYCLES(POWERUP_CYCLES)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sram_access_seq #(
        .WP_C  (WP_C),
        .CAP_C (CAP_C),
        .WLEN  (WLEN),
        .RLEN  (RLEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_wr (cmd_write),
        .busy     (busy),
        .cap      (cap),
        .cs_n     (mem_cs_n),
        .cs       (mem_cs),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe)
    );

    sram_data_path #(.AW(AW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .cap        (cap),
        .dq_in      (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Protocol checker for sram_async_ctrl, bound to every instance. It watches
// the port-level strobe ordering and keeps its own window counters.
module sram_async_ctrl_chk #(
    parameter int unsigned AW             = 21,
    parameter int unsigned DW             = 8,
    parameter int unsigned CLK_NS         = 10,
    parameter int unsigned T_PWE_NS       = 35,
    parameter int unsigned T_SD_NS        = 20,
    parameter int unsigned T_AW_NS        = 35,
    parameter int unsigned T_HZ_NS        = 15,
    parameter int unsigned POWERUP_CYCLES = 20000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_cs,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    import sram_ctrl_pkg::*;

    localparam int unsigned WP_C = max2(max2(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                        max2(ns_to_cyc(T_AW_NS, CLK_NS), 1));
    localparam int unsigned HZ_C = max2(ns_to_cyc(T_HZ_NS, CLK_NS), 1);

    int unsigned since_rst;
    logic [7:0]  we_low;
    logic [7:0]  oe_high;

    // Edges since reset, saturating at the power-up count.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= 0;
        else if (since_rst < POWERUP_CYCLES) since_rst <= since_rst + 1;
    end

    // Length of the current write-enable low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) we_low <= '0;
        else if (!mem_we_n && we_low != 8'hFF) we_low <= we_low + 1'b1;
        else if (mem_we_n) we_low <= '0;
    end

    // Edges since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_high <= 8'hFF;
        else if (!mem_oe_n) oe_high <= '0;
        else if (oe_high != 8'hFF) oe_high <= oe_high + 1'b1;
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R2
    powerup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (since_rst >= POWERUP_CYCLES));

    // R3
    select_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (!mem_cs_n && mem_cs));

    // R4
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));

    // R4
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

    // R4
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low >= 8'(WP_C)));

    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !cmd_ready);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && oe_high >= 8'(HZ_C)));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .AW             (AW),
    .DW             (DW),
    .CLK_NS         (CLK_NS),
    .T_PWE_NS       (T_PWE_NS),
    .T_SD_NS        (T_SD_NS),
    .T_AW_NS        (T_AW_NS),
    .T_HZ_NS        (T_HZ_NS),
    .POWERUP_CYCLES (POWERUP_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
// Bench for sram_async_ctrl: a behavioural memory model with pin-timing
// checks, a table of commands walked by one loop, and directed reset and
// power-up tests.
module sim_sram_async_ctrl;

    localparam int PWR   = 40;
    localparam int CLK   = 10;
    // Cycle counts worked out from the requirements at a 10 ns period.
    localparam int TC_C  = (45 + CLK - 1) / CLK;   // 5
    localparam int WP_C  = (35 + CLK - 1) / CLK;   // 4
    localparam int DS_C  = (20 + CLK - 1) / CLK;   // 2
    localparam int AA_C  = (45 + CLK - 1) / CLK;   // 5
    localparam int HZ_C  = (15 + CLK - 1) / CLK;   // 2
    localparam int LIMIT = 20000;

    typedef struct packed {
        logic        wr;
        logic [20:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 21'h000000, 8'h3C},
        '{1'b1, 21'h1FFFFF, 8'hC3},
        '{1'b0, 21'h000000, 8'h00},
        '{1'b0, 21'h1FFFFF, 8'h00},
        '{1'b1, 21'h0AAAAA, 8'h5A},
        '{1'b1, 21'h155555, 8'hA5},
        '{1'b0, 21'h155555, 8'h00},
        '{1'b0, 21'h0AAAAA, 8'h00},
        '{1'b1, 21'h000000, 8'hFF},
        '{1'b0, 21'h000000, 8'h00},
        '{1'b1, 21'h000001, 8'h00},
        '{1'b0, 21'h000001, 8'h00},
        '{1'b0, 21'h1FFFFF, 8'h00},
        '{1'b1, 21'h1FFFFF, 8'h7E},
        '{1'b0, 21'h1FFFFF, 8'h00},
        '{1'b0, 21'h0AAAAA, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [20:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [20:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    sram_async_ctrl #(.POWERUP_CYCLES(PWR)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            chk(1'b0, "watchdog", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- memory model with pin-timing checks ----------------
    logic [7:0]  mem_m [logic [20:0]];
    logic [7:0]  dq_drv = 8'h00;
    logic [20:0] last_addr = '0;
    logic        rd_prev = 1'b0, wr_prev = 1'b0;
    int          age = 0, rel = 255, wlow = 0, dst = 0;
    logic [7:0]  wd = '0;
    logic [20:0] wa = '0;
    int          commits = 0, contention = 0, wr_bad = 0, addr_bad = 0;
    logic        sel_prev = 1'b0;
    logic [20:0] sel_addr = '0;

    assign mem_dq_in = dq_drv;

    function automatic logic [7:0] rd_m(input logic [20:0] a);
        return mem_m.exists(a) ? mem_m[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        logic rd_now, wr_now, sel;
        sel    = !mem_cs_n && mem_cs;
        rd_now = sel && mem_we_n && !mem_oe_n;
        wr_now = sel && !mem_we_n;
        if (rst_n) begin
            // R5: address must not move while selected
            if (sel && sel_prev && mem_addr != sel_addr) addr_bad++;
            sel_prev = sel;
            sel_addr = mem_addr;
            // Read drive with access-time validity
            if (rd_now) begin
                age = (rd_prev && mem_addr == last_addr) ? age + 1 : 1;
                dq_drv = (age >= AA_C) ? rd_m(mem_addr) : ~rd_m(mem_addr);
                rel = 0;
            end else begin
                age = 0;
                dq_drv = 8'h00;
                if (rel < 255) rel++;
            end
            last_addr = mem_addr;
            rd_prev = rd_now;
            // R8: controller drives only after the memory has let go
            if (mem_dq_oe && (rd_now || rel <= HZ_C)) contention++;
            // R4: write pulse, setup and hold observed at the pins
            if (wr_now) begin
                if (!mem_dq_oe || !mem_oe_n) wr_bad++;
                if (!wr_prev) begin
                    wlow = 1; dst = 1; wd = mem_dq_out; wa = mem_addr;
                end else begin
                    wlow++;
                    if (mem_dq_out == wd) dst++;
                    else begin dst = 1; wd = mem_dq_out; end
                end
            end else if (wr_prev) begin
                chk(wlow >= WP_C, "R4 write pulse cycles", wlow, WP_C);
                chk(dst >= DS_C && mem_dq_oe && mem_dq_out == wd,
                    "R4 data setup/hold", dst, DS_C);
                mem_m[wa] = wd;
                commits++;
            end
            wr_prev = wr_now;
        end
    end

    // ---------------- command driver ----------------
    logic [7:0] shadow [logic [20:0]];
    int         last_acc = -1000;
    int         n_writes = 0;

    task automatic run_op(input vec_t v);
        int n, pulses, lat;
        logic [7:0] got, exp;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_write = v.wr;
        cmd_addr  = v.addr;
        cmd_wdata = v.data;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        if (last_acc >= 0)
            chk(cyc - last_acc >= TC_C, "R7 acceptance spacing", cyc - last_acc, TC_C);
        last_acc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, "R7 ready low in access", cmd_ready, 0);
        n = 1; pulses = 0; lat = 0; got = '0;
        while (!cmd_ready && n < 40) begin
            if (rsp_valid) begin
                pulses++;
                if (pulses == 1) begin lat = n; got = rsp_rdata; end
            end
            @(negedge clk);
            n++;
        end
        if (rsp_valid) pulses++;
        if (v.wr) begin
            shadow[v.addr] = v.data;
            n_writes++;
            chk(pulses == 0, "R6 no response for write", pulses, 0);
        end else begin
            exp = shadow.exists(v.addr) ? shadow[v.addr] : 8'h00;
            chk(pulses == 1, "R6 single response pulse", pulses, 1);
            chk(lat == AA_C + 1, "R6 capture latency", lat, AA_C + 1);
            chk(got == exp, "R9 read-back data", got, exp);
        end
        chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R3 deselected when ready", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    endtask

    initial begin
        int bad;
        // R1: reset levels with a command already pending
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        cmd_addr  = 21'h012345;
        cmd_wdata = 8'h99;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe && !cmd_ready,
            "R1 reset levels", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe, cmd_ready}, 6'b101100);
        rst_n = 1'b1;
        // R2: exact power-up edge, pending command ignored until then
        bad = 0;
        for (int i = 1; i <= PWR; i++) begin
            @(negedge clk);
            if (i < PWR && (cmd_ready || !mem_cs_n || !mem_we_n || mem_dq_oe)) bad++;
            if (i == PWR) begin
                chk(cmd_ready, "R2 ready after power-up", cmd_ready, 1);
                cmd_valid = 1'b0;
            end
        end
        chk(bad == 0, "R2 quiet during power-up", bad, 0);
        chk(commits == 0, "R2 no write during power-up", commits, 0);

        // Main table
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i]);
        end

        repeat (4) @(negedge clk);
        chk(commits == n_writes, "R4 writes committed", commits, n_writes);
        chk(wr_bad == 0, "R4 oe high and driving in write", wr_bad, 0);
        chk(contention == 0, "R8 bus contention", contention, 0);
        chk(addr_bad == 0, "R5 address stable", addr_bad, 0);
        chk(mem_m.exists(21'h155555) && mem_m[21'h155555] == 8'hA5,
            "R9 model content", rd_m(21'h155555), 8'hA5);

        // R1: mid-run reset returns to standby and restarts the wait
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && !cmd_ready, "R1 second reset", {mem_cs_n, cmd_ready}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_ready, "R2 wait restarts after reset", cmd_ready, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule